// File: doc/BRIEF.md
# Page-Directory Translation Cache

This block keeps up to eight partial address translations so that a page walker can skip the upper levels of a walk and start directly at the page table. A fill presents the upper bits of a linear address, the paging mode, the current process-context ID and three raw 64-bit directory entries (fourth-level, third-level and directory level). The block checks that the walk may be cached, merges the permissions across the levels that take part, and stores one combined entry.

A lookup presents the upper bits of a linear address, a mode and a context ID. In the same cycle the block returns hit, the page-table base and the merged permission and cache-control bits. If an accessed flag is clear in a level that takes part, the block asks for it to be set and caches only after that request is acknowledged. Entries can be flushed all at once or by context ID.

Linear-address ports carry address bits 47:21 only (`*_vpn[0]` is address bit 21). Paging modes are encoded 0 = 32-bit, 1 = PAE, 2 = 4-level, 3 = illegal.

Top module: `pgdir_xlat_cache`

## Requirements
- R1: The lookup key is address bits 31:22 in mode 0, bits 31:21 in mode 1 and bits 47:21 in mode 2. Address bits outside the key do not affect a hit.
- R2: Each directory entry is decoded as: bit 0 present, bit 1 write, bit 2 user, bit 3 write-through, bit 4 cache-disable, bit 5 accessed, bit 7 page-size, bit 8 global, bits 51:12 table base, bits 62:52 reserved, bit 63 execute-disable. On a hit, lk_base, lk_pcd and lk_pwt come from the directory-level entry.
- R3: The stored write and user bits are the AND over the levels that take part, and execute-disable is their OR. In mode 2 all three levels take part; in modes 0 and 1 only the directory level does, and the other two entries are ignored entirely.
- R4: A fill is refused with a one-cycle fill_reject pulse after the accepting edge, and nothing is stored, if the mode is 3 or if a level that takes part has present 0, page-size 1 or any reserved bit set.
- R5: If a legal fill has a clear accessed bit in a level that takes part, acc_set_req rises after the accepting edge with acc_set_mask giving the levels (bit 0 fourth-level, bit 1 third-level, bit 2 directory). Both hold until acc_set_ack. The entry is stored at the ack edge, and fill_valid is ignored while fill_busy is high.
- R6: A lookup hits only if the stored context ID and mode both equal the lookup's.
- R7: The lookup is combinational. A fill accepted at a clock edge is visible to lookups from then on, and fill_done pulses for one cycle. After reset nothing hits and no request is pending.
- R8: With no matching entry, fills use the eight slots in round-robin order, so the ninth distinct fill after a full flush evicts the first.
- R9: A fill whose key, mode and context ID match a valid entry overwrites that entry in place and evicts nothing.
- R10: inv_all invalidates every entry at the next edge. inv_ctx invalidates only the entries whose context ID equals inv_pcid. Stored entries otherwise stay unchanged.
- R11: The global bit has no effect on acceptance, stored values, hits or invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request |
| fill_mode | input | 2 | Paging mode of the fill |
| fill_pcid | input | 12 | Context ID of the fill |
| fill_vpn | input | 27 | Linear address bits 47:21 of the fill |
| fill_l4e | input | 64 | Fourth-level entry |
| fill_l3e | input | 64 | Third-level entry |
| fill_l2e | input | 64 | Directory-level entry |
| fill_busy | output | 1 | Fill waiting for accessed-bit acknowledge |
| fill_done | output | 1 | Pulse: entry stored |
| fill_reject | output | 1 | Pulse: fill refused |
| acc_set_req | output | 1 | Request to set accessed bits |
| acc_set_mask | output | 3 | Levels whose accessed bit must be set |
| acc_set_ack | input | 1 | Accessed bits have been set |
| lk_mode | input | 2 | Lookup paging mode |
| lk_pcid | input | 12 | Lookup context ID |
| lk_vpn | input | 27 | Lookup linear address bits 47:21 |
| lk_hit | output | 1 | Lookup hit |
| lk_base | output | 40 | Page-table base (physical bits 51:12) |
| lk_rw | output | 1 | Merged write permission |
| lk_us | output | 1 | Merged user permission |
| lk_xd | output | 1 | Merged execute-disable |
| lk_pcd | output | 1 | Directory cache-disable |
| lk_pwt | output | 1 | Directory write-through |
| inv_all | input | 1 | Flush all entries |
| inv_ctx | input | 1 | Flush entries of one context |
| inv_pcid | input | 12 | Context ID for inv_ctx |

## Verification
The assertions assume that acc_set_ack is raised only while acc_set_req is high, and that fill inputs are valid whenever fill_valid is high. They also assume that a fill is never stored in the same cycle as an invalidation, because the check that entries persist looks only at cycles with neither. The stimulus runs fills, lookups and invalidations one after another and never overlaps them. It raises the acknowledge only after it has seen the request, and during a pending fill it offers a single decoy fill that must be ignored.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  localparam int VPN_W  = 27;
  localparam int PCID_W = 12;
  localparam int TAG_W  = 27;
  localparam int BASE_W = 40;
  localparam int ENT_W  = 64;

  localparam int B_P   = 0;
  localparam int B_RW  = 1;
  localparam int B_US  = 2;
  localparam int B_PWT = 3;
  localparam int B_PCD = 4;
  localparam int B_A   = 5;
  localparam int B_PS  = 7;
  localparam int B_XD  = 63;
  localparam int RSV_LO = 52;
  localparam int RSV_HI = 62;
  localparam int BASE_LO = 12;

  typedef enum logic [1:0] {
    PM_32  = 2'd0,
    PM_PAE = 2'd1,
    PM_L4  = 2'd2,
    PM_BAD = 2'd3
  } pmode_e;

  typedef struct packed {
    logic              valid;
    logic [1:0]        mode;
    logic [PCID_W-1:0] pcid;
    logic [TAG_W-1:0]  tag;
    logic [BASE_W-1:0] base;
    logic              rw;
    logic              us;
    logic              xd;
    logic              pcd;
    logic              pwt;
  } pdx_ent_t;

  // key taken from address bits 47:21 according to mode
  function automatic logic [TAG_W-1:0] tag_of(logic [1:0] mode, logic [VPN_W-1:0] vpn);
    case (mode)
      PM_32:   tag_of = {17'b0, vpn[10:1]};
      PM_PAE:  tag_of = {16'b0, vpn[10:0]};
      default: tag_of = vpn;
    endcase
  endfunction

  // one level may be cached: present, points to a table, reserved clear
  function automatic logic lvl_ok(logic [ENT_W-1:0] e);
    lvl_ok = e[B_P] & ~e[B_PS] & (e[RSV_HI:RSV_LO] == '0);
  endfunction

  // levels that take part: bit0 fourth, bit1 third, bit2 directory
  function automatic logic [2:0] live_mask(logic [1:0] mode);
    live_mask = (mode == PM_L4) ? 3'b111 : 3'b100;
  endfunction

  function automatic pdx_ent_t build_ent(logic [1:0] mode, logic [PCID_W-1:0] pcid,
                                         logic [VPN_W-1:0] vpn, logic [ENT_W-1:0] e4,
                                         logic [ENT_W-1:0] e3, logic [ENT_W-1:0] e2);
    pdx_ent_t r;
    logic up;
    up      = (mode == PM_L4);
    r.valid = 1'b1;
    r.mode  = mode;
    r.pcid  = pcid;
    r.tag   = tag_of(mode, vpn);
    r.base  = e2[BASE_LO +: BASE_W];
    r.rw    = e2[B_RW] & (~up | (e4[B_RW] & e3[B_RW]));
    r.us    = e2[B_US] & (~up | (e4[B_US] & e3[B_US]));
    r.xd    = e2[B_XD] | (up & (e4[B_XD] | e3[B_XD]));
    r.pcd   = e2[B_PCD];
    r.pwt   = e2[B_PWT];
    return r;
  endfunction
endpackage

// File: rtl/pdx_fill_ctrl.sv
module pdx_fill_ctrl
  import pdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [1:0]        fill_mode,
  input  logic [PCID_W-1:0] fill_pcid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ENT_W-1:0]  fill_l4e,
  input  logic [ENT_W-1:0]  fill_l3e,
  input  logic [ENT_W-1:0]  fill_l2e,
  input  logic              acc_set_ack,
  output logic              fill_busy,
  output logic              fill_done,
  output logic              fill_reject,
  output logic              acc_set_req,
  output logic [2:0]        acc_set_mask,
  output logic              wr_en,
  output pdx_ent_t          wr_ent
);
  logic [2:0] live, good, acc_bits, need;
  logic       accept, legal;
  logic       wait_q, done_q, rej_q;
  logic [2:0] mask_q;
  pdx_ent_t   new_ent, held_q;

  assign live     = live_mask(fill_mode);
  assign good     = {lvl_ok(fill_l2e), lvl_ok(fill_l3e), lvl_ok(fill_l4e)};
  assign acc_bits = {fill_l2e[B_A], fill_l3e[B_A], fill_l4e[B_A]};
  assign legal    = (fill_mode != PM_BAD) && ((live & ~good) == 3'b000);
  assign need     = live & ~acc_bits;
  assign new_ent  = build_ent(fill_mode, fill_pcid, fill_vpn, fill_l4e, fill_l3e, fill_l2e);
  assign accept   = fill_valid & ~wait_q;

  assign wr_en  = (accept & legal & (need == 3'b000)) | (wait_q & acc_set_ack);
  assign wr_ent = wait_q ? held_q : new_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      mask_q <= '0;
      held_q <= '0;
    end else begin
      done_q <= wr_en;
      rej_q  <= accept & ~legal;
      if (accept && legal && (need != 3'b000)) begin
        wait_q <= 1'b1;
        mask_q <= need;
        held_q <= new_ent;
      end else if (wait_q && acc_set_ack) begin
        wait_q <= 1'b0;
        mask_q <= '0;
      end
    end
  end

  assign fill_busy    = wait_q;
  assign acc_set_req  = wait_q;
  assign acc_set_mask = mask_q;
  assign fill_done    = done_q;
  assign fill_reject  = rej_q;

  // R4
  done_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_done && fill_reject));
  // R5
  req_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_set_req |-> (acc_set_mask != 3'b000));
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_set_req && !acc_set_ack) |=> (acc_set_req && $stable(acc_set_mask)));
  // R5
  req_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_set_req && acc_set_ack) |=> (fill_done && !acc_set_req));
endmodule

// File: rtl/pdx_entry_array.sv
module pdx_entry_array
  import pdx_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  pdx_ent_t          wr_ent,
  input  logic              inv_all,
  input  logic              inv_ctx,
  input  logic [PCID_W-1:0] inv_pcid,
  output pdx_ent_t          ents [NUM_ENT]
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0] same_key, kill, valid_vec;
  logic [IDX_W-1:0]   rr_q, same_idx, slot;
  logic               any_same;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    pdx_ent_t e_q;
    assign same_key[g]  = e_q.valid && (e_q.mode == wr_ent.mode) &&
                          (e_q.pcid == wr_ent.pcid) && (e_q.tag == wr_ent.tag);
    assign kill[g]      = inv_all | (inv_ctx & (e_q.pcid == inv_pcid));
    assign valid_vec[g] = e_q.valid;
    assign ents[g]      = e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= '0;
      end else if (wr_en && (slot == IDX_W'(g))) begin
        e_q       <= wr_ent;
        e_q.valid <= 1'b1;
      end else if (kill[g]) begin
        e_q.valid <= 1'b0;
      end
    end
  end

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (same_key[i]) same_idx = IDX_W'(i);
  end
  assign any_same = |same_key;
  assign slot     = any_same ? same_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_q <= '0;
    else if (wr_en && !any_same)
      rr_q <= (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  // R9
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(same_key));
  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !wr_en) |=> (valid_vec == '0));
  // R10
  persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inv_all && !inv_ctx) |=> $stable(valid_vec));
  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_vec != '0));
endmodule

// File: rtl/pdx_lookup.sv
module pdx_lookup
  import pdx_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pdx_ent_t          ents [NUM_ENT],
  input  logic [1:0]        lk_mode,
  input  logic [PCID_W-1:0] lk_pcid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output pdx_ent_t          res
);
  logic [NUM_ENT-1:0] hit_vec;
  logic [TAG_W-1:0]   key;

  assign key = tag_of(lk_mode, lk_vpn);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ents[g].valid && (ents[g].mode == lk_mode) &&
                        (ents[g].pcid == lk_pcid) && (ents[g].tag == key);
  end

  always_comb begin
    res = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (hit_vec[i]) res = res | ents[i];
  end
  assign hit = |hit_vec;

  // R9
  lookup_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R6
  illegal_mode_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_mode == PM_BAD) |-> !hit);
endmodule

// File: rtl/pgdir_xlat_cache.sv
module pgdir_xlat_cache
  import pdx_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [1:0]        fill_mode,
  input  logic [PCID_W-1:0] fill_pcid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ENT_W-1:0]  fill_l4e,
  input  logic [ENT_W-1:0]  fill_l3e,
  input  logic [ENT_W-1:0]  fill_l2e,
  output logic              fill_busy,
  output logic              fill_done,
  output logic              fill_reject,
  output logic              acc_set_req,
  output logic [2:0]        acc_set_mask,
  input  logic              acc_set_ack,
  input  logic [1:0]        lk_mode,
  input  logic [PCID_W-1:0] lk_pcid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [BASE_W-1:0] lk_base,
  output logic              lk_rw,
  output logic              lk_us,
  output logic              lk_xd,
  output logic              lk_pcd,
  output logic              lk_pwt,
  input  logic              inv_all,
  input  logic              inv_ctx,
  input  logic [PCID_W-1:0] inv_pcid
);
  logic     wr_en;
  pdx_ent_t wr_ent;
  pdx_ent_t ents [NUM_ENT];
  pdx_ent_t res;

  pdx_fill_ctrl u_fill (
    .clk, .rst_n, .fill_valid, .fill_mode, .fill_pcid, .fill_vpn,
    .fill_l4e, .fill_l3e, .fill_l2e, .acc_set_ack,
    .fill_busy, .fill_done, .fill_reject, .acc_set_req, .acc_set_mask,
    .wr_en, .wr_ent
  );

  pdx_entry_array #(.NUM_ENT(NUM_ENT)) u_array (
    .clk, .rst_n, .wr_en, .wr_ent, .inv_all, .inv_ctx, .inv_pcid, .ents
  );

  pdx_lookup #(.NUM_ENT(NUM_ENT)) u_lookup (
    .clk, .rst_n, .ents, .lk_mode, .lk_pcid, .lk_vpn, .hit(lk_hit), .res
  );

  assign lk_base = res.base;
  assign lk_rw   = res.rw;
  assign lk_us   = res.us;
  assign lk_xd   = res.xd;
  assign lk_pcd  = res.pcd;
  assign lk_pwt  = res.pwt;

  logic unused_res;
  assign unused_res = ^{res.valid, res.mode, res.pcid, res.tag};

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_base == '0 && !lk_rw && !lk_us && !lk_xd));
endmodule

// File: tb/test_pgdir_xlat_cache.sv
`timescale 1ns/1ps
module test_pgdir_xlat_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        fill_valid = 0, acc_set_ack = 0, inv_all = 0, inv_ctx = 0;
  logic [1:0]  fill_mode = 0, lk_mode = 0;
  logic [11:0] fill_pcid = 0, lk_pcid = 0, inv_pcid = 0;
  logic [26:0] fill_vpn = 0, lk_vpn = 0;
  logic [63:0] fill_l4e = 0, fill_l3e = 0, fill_l2e = 0;
  logic        fill_busy, fill_done, fill_reject, acc_set_req, lk_hit;
  logic        lk_rw, lk_us, lk_xd, lk_pcd, lk_pwt;
  logic [2:0]  acc_set_mask;
  logic [39:0] lk_base;

  pgdir_xlat_cache i_pgdir_xlat_cache (.*);

  int total = 0, bad = 0;
  bit          r_v [8];
  logic [1:0]  r_m [8];
  logic [11:0] r_p [8];
  logic [26:0] r_k [8];
  logic [39:0] r_b [8];
  logic [4:0]  r_f [8];
  int          r_ptr = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [26:0] b_key(input logic [1:0] m, input logic [47:0] la);
    if (m == 2'd0) return 27'((la >> 22) & 48'h3FF);
    if (m == 2'd1) return 27'((la >> 21) & 48'h7FF);
    return 27'(la >> 21);
  endfunction

  // p rw us a ps xd at bits 0 1 2 5 7 63, base at 51:12
  function automatic logic [63:0] mk(input logic [39:0] b, input bit p, input bit rw,
                                     input bit us, input bit a, input bit ps, input bit xd);
    logic [63:0] e = 64'(b) << 12;
    e[0] = p; e[1] = rw; e[2] = us; e[5] = a; e[7] = ps; e[63] = xd;
    return e;
  endfunction
  function automatic logic [63:0] gd(input logic [39:0] b);
    return mk(b, 1, 1, 1, 1, 0, 0);
  endfunction
  function automatic bit cacheable(input logic [63:0] e);
    return e[0] && !e[7] && ((e >> 52) & 64'h7FF) == 0;
  endfunction

  task automatic model_put(input logic [1:0] m, input logic [11:0] pc, input logic [47:0] la,
                           input logic [39:0] b, input logic [4:0] f);
    int slot = -1;
    for (int i = 0; i < 8; i++)
      if (r_v[i] && r_m[i] == m && r_p[i] == pc && r_k[i] == b_key(m, la)) slot = i;
    if (slot < 0) begin slot = r_ptr; r_ptr = (r_ptr + 1) % 8; end
    r_v[slot] = 1; r_m[slot] = m; r_p[slot] = pc; r_k[slot] = b_key(m, la);
    r_b[slot] = b; r_f[slot] = f;
  endtask

  task automatic do_fill(input logic [1:0] m, input logic [11:0] pc, input logic [47:0] la,
                         input logic [63:0] e4, input logic [63:0] e3, input logic [63:0] e2,
                         input int dly, input bit decoy);
    bit up = (m == 2'd2);
    bit ok;
    logic [2:0] need;
    logic [4:0] f;
    ok   = (m != 2'd3) && cacheable(e2) && (!up || (cacheable(e3) && cacheable(e4)));
    need = {~e2[5], up & ~e3[5], up & ~e4[5]};
    f    = {e2[1] && (!up || (e4[1] && e3[1])), e2[2] && (!up || (e4[2] && e3[2])),
            e2[63] || (up && (e4[63] || e3[63])), e2[4], e2[3]};
    @(negedge clk);
    fill_valid = 1; fill_mode = m; fill_pcid = pc; fill_vpn = la[47:21];
    fill_l4e = e4; fill_l3e = e3; fill_l2e = e2;
    @(posedge clk); #1 fill_valid = 0;
    if (!ok) begin
      chk(fill_reject && !fill_done, "R4", "reject pulse", {fill_reject, fill_done}, 2'b10);
    end else if (need == 0) begin
      chk(fill_done && !acc_set_req, "R7", "done pulse", {fill_done, acc_set_req}, 2'b10);
      model_put(m, pc, la, e2[51:12], f);
    end else begin
      chk(acc_set_req && acc_set_mask == need && fill_busy, "R5", "accessed request",
          {acc_set_req, acc_set_mask}, {1'b1, need});
      if (decoy) begin
        fill_valid = 1; fill_pcid = pc + 12'd1; fill_l4e = gd(1); fill_l3e = gd(2); fill_l2e = gd(3);
        @(posedge clk); #1 fill_valid = 0;
        chk(!fill_done && !fill_reject && acc_set_req, "R5", "decoy ignored",
            {fill_done, fill_reject, acc_set_req}, 3'b001);
      end
      for (int i = 0; i < dly; i++) begin
        @(posedge clk); #1;
        chk(acc_set_req && acc_set_mask == need, "R5", "request held",
            {acc_set_req, acc_set_mask}, {1'b1, need});
      end
      @(negedge clk); acc_set_ack = 1;
      @(posedge clk); #1 acc_set_ack = 0;
      chk(fill_done && !acc_set_req, "R5", "done after ack", {fill_done, acc_set_req}, 2'b10);
      model_put(m, pc, la, e2[51:12], f);
    end
  endtask

  task automatic check_lk(input logic [1:0] m, input logic [11:0] pc, input logic [47:0] la,
                          input string rq);
    int idx = -1;
    lk_mode = m; lk_pcid = pc; lk_vpn = la[47:21];
    #1;
    for (int i = 0; i < 8; i++)
      if (r_v[i] && r_m[i] == m && r_p[i] == pc && r_k[i] == b_key(m, la)) idx = i;
    if (idx < 0) chk(!lk_hit, rq, "expected miss", lk_hit, 0);
    else begin
      chk(lk_hit && lk_base == r_b[idx], rq, "hit base", {lk_hit, lk_base}, {1'b1, r_b[idx]});
      chk({lk_rw, lk_us, lk_xd, lk_pcd, lk_pwt} == r_f[idx], rq, "merged bits",
          {lk_rw, lk_us, lk_xd, lk_pcd, lk_pwt}, r_f[idx]);
    end
  endtask

  task automatic do_inv(input bit all, input logic [11:0] pc);
    @(negedge clk);
    inv_all = all; inv_ctx = !all; inv_pcid = pc;
    @(posedge clk); #1 inv_all = 0; inv_ctx = 0;
    for (int i = 0; i < 8; i++) if (all || r_p[i] == pc) r_v[i] = 0;
  endtask

  function automatic logic [63:0] rnd_ent(input logic [39:0] b);
    logic [63:0] e = mk(b, ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                        ($urandom % 4) != 0, ($urandom % 12) == 0, $urandom % 2);
    e[3] = $urandom % 2; e[4] = $urandom % 2; e[8] = $urandom % 2;
    if (($urandom % 16) == 0) e[55] = 1;
    return e;
  endfunction

  initial begin
    #1600000;
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(!lk_hit && !acc_set_req && !fill_busy, "R7", "reset state",
        {lk_hit, acc_set_req, fill_busy}, 0);

    // R1 key ranges per mode
    do_fill(0, 1, 48'h0000_00C0_0000, 0, 0, gd(40'h111), 0, 0);
    check_lk(0, 1, 48'h0000_00FF_FFFF, "R1");
    check_lk(0, 1, 48'h0000_0080_0000, "R1");
    do_fill(1, 1, 48'h0000_0020_0000, 0, 0, gd(40'h222), 0, 0);
    check_lk(1, 1, 48'h0000_003F_FFFF, "R1");
    check_lk(1, 1, 48'h0000_0000_0000, "R1");
    do_fill(2, 1, 48'h8000_0000_0000, gd(1), gd(2), gd(40'h333), 0, 0);
    check_lk(2, 1, 48'h8000_001F_FFFF, "R1");
    check_lk(2, 1, 48'h0000_0000_0000, "R1");
    // R6 context and mode must match
    check_lk(2, 2, 48'h8000_0000_0000, "R6");
    check_lk(1, 1, 48'h0000_00C0_0000, "R6");
    // R2 R3 merge across levels, cache control from directory level
    do_fill(2, 3, 48'h0000_4000_0000, mk(5, 1, 0, 1, 1, 0, 0), mk(6, 1, 1, 0, 1, 0, 1),
            64'(gd(40'hABCDE)) | 64'h18, 0, 0);
    check_lk(2, 3, 48'h0000_4000_0000, "R3");
    // R3 upper levels ignored in mode 0
    do_fill(0, 3, 48'h0000_4000_0000, 64'h0, mk(0, 0, 0, 0, 0, 1, 1), gd(40'h777), 0, 0);
    check_lk(0, 3, 48'h0000_4000_0000, "R3");
    // R4 refusals
    do_fill(2, 4, 48'h0000_0060_0000, gd(1), gd(2), mk(3, 0, 1, 1, 1, 0, 0), 0, 0);
    do_fill(2, 4, 48'h0000_0060_0000, gd(1), mk(2, 1, 1, 1, 1, 1, 0), gd(3), 0, 0);
    do_fill(2, 4, 48'h0000_0060_0000, gd(1) | 64'h0010_0000_0000_0000, gd(2), gd(3), 0, 0);
    do_fill(3, 4, 48'h0000_0060_0000, gd(1), gd(2), gd(3), 0, 0);
    check_lk(2, 4, 48'h0000_0060_0000, "R4");
    check_lk(3, 4, 48'h0000_0060_0000, "R4");
    // R5 accessed handshake with decoy
    do_fill(2, 7, 48'h0000_0080_0000, mk(1, 1, 1, 1, 0, 0, 0), gd(2), mk(3, 1, 1, 1, 0, 0, 0), 3, 1);
    check_lk(2, 7, 48'h0000_0080_0000, "R5");
    check_lk(2, 8, 48'h0000_0080_0000, "R5");
    // R11 global bit has no effect
    do_fill(2, 9, 48'h0000_00A0_0000, gd(1) | 64'h100, gd(2) | 64'h100, gd(40'h999) | 64'h100, 0, 0);
    check_lk(2, 9, 48'h0000_00A0_0000, "R11");
    do_inv(0, 9);
    check_lk(2, 9, 48'h0000_00A0_0000, "R11");
    // R8 round robin after full flush
    do_inv(1, 0);
    check_lk(2, 1, 48'h8000_0000_0000, "R10");
    r_ptr = r_ptr;
    for (int i = 0; i < 9; i++)
      do_fill(2, 5, 48'(i) << 21, gd(1), gd(2), gd(40'(16'h100 + i)), 0, 0);
    check_lk(2, 5, 48'h0, "R8");
    for (int i = 1; i < 9; i++) check_lk(2, 5, 48'(i) << 21, "R8");
    // R9 in-place refill
    do_fill(2, 5, 48'(3) << 21, gd(1), gd(2), gd(40'h5555), 0, 0);
    for (int i = 1; i < 9; i++) check_lk(2, 5, 48'(i) << 21, "R9");
    // R10 per-context flush
    do_fill(2, 6, 48'h0, gd(1), gd(2), gd(40'h66), 0, 0);
    do_inv(0, 5);
    check_lk(2, 5, 48'(4) << 21, "R10");
    check_lk(2, 6, 48'h0, "R10");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom % 10;
      logic [1:0]  m  = (($urandom % 20) == 0) ? 2'd3 : 2'($urandom % 3);
      logic [11:0] pc = 12'(1 + $urandom % 3);
      logic [47:0] la = (48'($urandom % 12) << 22) | (48'($urandom) & 48'h3F_FFFF);
      if (op < 5)
        do_fill(m, pc, la, rnd_ent(40'($urandom)), rnd_ent(40'($urandom)),
                rnd_ent(40'($urandom)), $urandom % 3, ($urandom % 4) == 0);
      else if (op == 9)
        do_inv(($urandom % 2) == 0, pc);
      check_lk(m, pc, la, "R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule